// File: doc/BRIEF.md
# Three-phase center-aligned PWM generator

This block drives the six gate signals of a three-phase inverter bridge: one high-side and one low-side output for each of phases A, B and C. A single up/down counter sets the timing for all three phases, so every pulse is centred on the start of the switching period. Software writes a period, three duty values, a dead time, a minimum pulse width, a chopping divisor and a control word through a simple write port.

The duty, period, dead-time and minimum-width values are double buffered. They take effect only on a reload boundary, once per period or, in double-update mode, also at the midpoint. Dead time is taken off both edges of every pulse, so the two switches of a leg are never on together. A pulse that would be shorter than the programmed minimum is dropped. A duty beyond the period holds the high side on for the whole period. The outputs can be chopped by a fast square wave, enabled one by one, and flipped between active-high and active-low by a strap input. A trip input forces every output to its inactive level at once, with no clock needed. Synchronous shutdown inputs set the same latch, which only a software clear releases.

Top module: `pwm3_gen`

## Requirements
- R1: The counter runs 0, 1, …, P, P−1, …, 1 and repeats, so one switching period lasts 2·P clocks for period value P ≥ 1. `sync` is a one-clock pulse at each period start. In single-update mode it pulses once per period. The period value after reset is 100.
- R2: With th_hi = max(duty − dead, 0) and th_lo = duty + dead, the high side is active while the count is below th_hi and the low side is active while the count is at or above th_lo. Over a period the high side is therefore active 2·th_hi − 1 clocks and the low side 2·(P − th_lo) + 1 clocks. The two sides of a phase are never active together.
- R3: When th_hi exceeds P, the high side is active for the whole period and the low side stays off. This gives 100 % duty with no edges.
- R4: A pulse of nonzero length that would last fewer clocks than the minimum-width value is removed, and that output stays off for the whole period. Full-period pulses are never removed.
- R5: When control bit 0 is set (double update), reloads and `sync` pulses happen at both the period start and the midpoint (count = P), which gives two `sync` pulses per period.
- R6: Writes to period, duty, dead time and minimum width go to holding registers. They take effect at the next reload, and the period that is running finishes with the old values.
- R7: Control bits 1..6 enable AH, AL, BH, BL, CH and CL in that order. A disabled output sits at its inactive level from the clock after the bit clears. All enables are clear after reset.
- R8: With `pol_high` = 1 the outputs are active high. With `pol_high` = 0 all six are active low.
- R9: Control bit 7 gates the high-side outputs, and control bit 8 gates the low-side outputs, with a square wave that toggles every (chop divisor + 1) clocks.
- R10: Asserting `trip_in` forces all six outputs inactive at once, without a clock edge. The shutdown stays latched after `trip_in` falls.
- R11: Any `ext_shut` bit sampled high at a clock edge sets the same shutdown latch.
- R12: Writing the control word with bit 15 set clears the latch. The clear has no effect while `trip_in` is still high.
- R13: The write addresses are: 0 period, 1 duty A, 2 duty B, 3 duty C, 4 dead time, 5 minimum width, 6 control, 7 chop divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pol_high | input | 1 | Polarity strap: 1 active high, 0 active low |
| trip_in | input | 1 | Asynchronous shutdown, active high |
| ext_shut | input | NSHUT | Synchronous shutdown requests |
| ah | output | 1 | Phase A high-side gate |
| al | output | 1 | Phase A low-side gate |
| bh | output | 1 | Phase B high-side gate |
| bl | output | 1 | Phase B low-side gate |
| ch | output | 1 | Phase C high-side gate |
| cl | output | 1 | Phase C low-side gate |
| sync | output | 1 | Reload pulse, aligned with the outputs |

## Verification
A register write can arrive in the same period as a reload that it must not disturb. The bench provokes this by writing a new duty immediately after a `sync` pulse. It then expects the current period's on-time to match the old duty and the following period's on-time to match the new one. A latch clear can also coincide with a still-asserted trip. The bench holds `trip_in` high while it writes the clear bit, then releases the trip and judges the outputs at the pins: they must stay inactive until a second clear is written.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int CW  = 16;
    localparam int NPH = 3;
    localparam int NOUT = 2 * NPH;

    typedef logic [CW-1:0] cnt_t;
    typedef logic [CW+1:0] wid_t;

    typedef enum logic [2:0] {
        RA_PERIOD = 3'd0,
        RA_DUTY_A = 3'd1,
        RA_DUTY_B = 3'd2,
        RA_DUTY_C = 3'd3,
        RA_DEAD   = 3'd4,
        RA_MINW   = 3'd5,
        RA_CTRL   = 3'd6,
        RA_CHOP   = 3'd7
    } reg_addr_e;

    // control word bit positions
    localparam int CB_DOUBLE = 0;
    localparam int CB_EN_LO  = 1;
    localparam int CB_CHOP_H = 7;
    localparam int CB_CHOP_L = 8;
    localparam int CB_CLEAR  = 15;

    typedef struct packed {
        cnt_t             period;
        cnt_t             dead;
        cnt_t             minw;
        cnt_t [NPH-1:0]   duty;
    } timing_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    function automatic logic too_short(input wid_t width, input cnt_t minw);
        return width < {2'b00, minw};
    endfunction

endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t period,
    input  logic dbl,
    output cnt_t cnt,
    output cnt_t cnt_d,
    output logic reload,
    output logic sync
);

    logic       up;
    logic [1:0] sync_sr;

    // start of period or (double update) the turning point
    assign reload = (cnt == '0) | (dbl & up & (cnt >= period));
    assign sync   = sync_sr[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cnt_d   <= '0;
            up      <= 1'b1;
            sync_sr <= '0;
        end else begin
            cnt_d   <= cnt;
            sync_sr <= {sync_sr[0], reload};
            if (up) begin
                if (cnt >= period) begin
                    if (cnt != '0) begin
                        cnt <= cnt - cnt_t'(1);
                        up  <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + cnt_t'(1);
                end
            end else begin
                if (cnt == '0) begin
                    cnt <= cnt_t'(1);
                    up  <= 1'b1;
                end else begin
                    cnt <= cnt - cnt_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg
    import pwm3_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cnt_t  cnt,
    input  cnt_t  period,
    input  cnt_t  duty,
    input  cnt_t  dead,
    input  cnt_t  minw,
    input  logic  en_hi,
    input  logic  en_lo,
    output gate_t act
);

    cnt_t          th_hi;
    logic [CW:0]   th_lo;
    logic [CW:0]   per_x;
    wid_t          w_hi;
    wid_t          w_lo;
    logic          hi_full, hi_none, lo_full, lo_none;
    logic          hi_raw, lo_raw;

    always_comb begin
        per_x   = {1'b0, period};
        th_hi   = (duty > dead) ? (duty - dead) : '0;
        th_lo   = {1'b0, duty} + {1'b0, dead};
        w_hi    = {1'b0, th_hi, 1'b0} - wid_t'(1);
        w_lo    = {per_x - th_lo, 1'b0} + wid_t'(1);
        hi_full = th_hi > period;
        hi_none = (th_hi == '0) || (!hi_full && too_short(w_hi, minw));
        lo_full = (th_lo == '0);
        lo_none = (th_lo > per_x) || (!lo_full && too_short(w_lo, minw));
        hi_raw  = !hi_none && (hi_full || (cnt < th_hi));
        lo_raw  = !lo_none && (lo_full || ({1'b0, cnt} >= th_lo));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
        end else begin
            act.hi <= hi_raw & en_hi;
            act.lo <= lo_raw & en_lo;
        end
    end

endmodule

// File: rtl/pwm3_outstage.sv
module pwm3_outstage
    import pwm3_pkg::*;
#(
    parameter int NSHUT = 2
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [NOUT-1:0]  act,
    input  logic             chop_hi,
    input  logic             chop_lo,
    input  cnt_t             chop_div,
    input  logic             trip_in,
    input  logic [NSHUT-1:0] ext_shut,
    input  logic             clr,
    input  logic             pol_high,
    output logic [NOUT-1:0]  pins
);

    cnt_t chop_cnt;
    logic chop_q;
    logic latched;
    logic kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            chop_cnt <= '0;
            chop_q   <= 1'b1;
        end else if (chop_cnt >= chop_div) begin
            chop_cnt <= '0;
            chop_q   <= ~chop_q;
        end else begin
            chop_cnt <= chop_cnt + cnt_t'(1);
        end
    end

    always_ff @(posedge clk or posedge trip_in) begin
        if (trip_in) begin
            latched <= 1'b1;
        end else if (rst) begin
            latched <= 1'b0;
        end else if (|ext_shut) begin
            latched <= 1'b1;
        end else if (clr) begin
            latched <= 1'b0;
        end
    end

    assign kill = trip_in | latched;

    for (genvar i = 0; i < NOUT; i++) begin : g_pin
        logic gate_ok;
        logic on;
        if (i % 2 == 0) begin : g_hi
            assign gate_ok = chop_hi ? chop_q : 1'b1;
        end else begin : g_lo
            assign gate_ok = chop_lo ? chop_q : 1'b1;
        end
        assign on      = act[i] & gate_ok & ~kill;
        assign pins[i] = pol_high ? on : ~on;
    end

endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int   NSHUT      = 2,
    parameter cnt_t RST_PERIOD = cnt_t'(100)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CW-1:0]    wr_data,
    input  logic             pol_high,
    input  logic             trip_in,
    input  logic [NSHUT-1:0] ext_shut,
    output logic             ah,
    output logic             al,
    output logic             bh,
    output logic             bl,
    output logic             ch,
    output logic             cl,
    output logic             sync
);

    localparam timing_t TIMING_RST = '{period: RST_PERIOD, dead: '0, minw: '0, duty: '0};

    timing_t         shadow_q, act_q;
    logic            dbl_q, chop_hi_q, chop_lo_q, clr_q;
    logic [NOUT-1:0] en_q;
    cnt_t            chop_div_q;
    cnt_t            cnt_now, cnt_d, per_now;
    logic            reload;
    logic [NOUT-1:0] act_vec, pin_vec;

    assign per_now = act_q.period;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q   <= TIMING_RST;
            dbl_q      <= 1'b0;
            en_q       <= '0;
            chop_hi_q  <= 1'b0;
            chop_lo_q  <= 1'b0;
            chop_div_q <= '0;
            clr_q      <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    RA_PERIOD: shadow_q.period  <= wr_data;
                    RA_DUTY_A: shadow_q.duty[0] <= wr_data;
                    RA_DUTY_B: shadow_q.duty[1] <= wr_data;
                    RA_DUTY_C: shadow_q.duty[2] <= wr_data;
                    RA_DEAD:   shadow_q.dead    <= wr_data;
                    RA_MINW:   shadow_q.minw    <= wr_data;
                    RA_CTRL: begin
                        dbl_q     <= wr_data[CB_DOUBLE];
                        en_q      <= wr_data[CB_EN_LO +: NOUT];
                        chop_hi_q <= wr_data[CB_CHOP_H];
                        chop_lo_q <= wr_data[CB_CHOP_L];
                        clr_q     <= wr_data[CB_CLEAR];
                    end
                    default:   chop_div_q <= wr_data;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= TIMING_RST;
        end else if (reload) begin
            act_q <= shadow_q;
        end
    end

    pwm3_timebase u_tb (
        .clk    (clk),
        .rst    (rst),
        .period (act_q.period),
        .dbl    (dbl_q),
        .cnt    (cnt_now),
        .cnt_d  (cnt_d),
        .reload (reload),
        .sync   (sync)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        gate_t g;
        pwm3_leg u_leg (
            .clk    (clk),
            .rst    (rst),
            .cnt    (cnt_d),
            .period (act_q.period),
            .duty   (act_q.duty[p]),
            .dead   (act_q.dead),
            .minw   (act_q.minw),
            .en_hi  (en_q[2*p]),
            .en_lo  (en_q[2*p+1]),
            .act    (g)
        );
        assign act_vec[2*p]   = g.hi;
        assign act_vec[2*p+1] = g.lo;
    end

    pwm3_outstage #(.NSHUT(NSHUT)) u_out (
        .clk      (clk),
        .rst      (rst),
        .act      (act_vec),
        .chop_hi  (chop_hi_q),
        .chop_lo  (chop_lo_q),
        .chop_div (chop_div_q),
        .trip_in  (trip_in),
        .ext_shut (ext_shut),
        .clr      (clr_q),
        .pol_high (pol_high),
        .pins     (pin_vec)
    );

    assign ah = pin_vec[0];
    assign al = pin_vec[1];
    assign bh = pin_vec[2];
    assign bl = pin_vec[3];
    assign ch = pin_vec[4];
    assign cl = pin_vec[5];

endmodule

// File: rtl/pwm3_gen_chk.sv
module pwm3_gen_chk
    import pwm3_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            pol_high,
    input logic            trip_in,
    input logic [NOUT-1:0] pins,
    input logic            sync,
    input cnt_t            cnt,
    input cnt_t            per_act,
    input logic [NOUT-1:0] en
);

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        // R2: both sides of one leg never active together
        a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
            !((pins[2*p] == pol_high) && (pins[2*p+1] == pol_high)));
    end

    for (genvar i = 0; i < NOUT; i++) begin : g_en
        // R7: a cleared enable gives an inactive pin one clock later
        a_r7_disable: assert property (@(posedge clk) disable iff (rst)
            !en[i] |=> (pins[i] != pol_high));
    end

    // R10: trip forces every pin inactive
    a_r10_trip_kills: assert property (@(posedge clk) disable iff (rst)
        trip_in |-> (pins == {NOUT{~pol_high}}));

    // R1: sync is a single-clock pulse
    a_r1_sync_pulse: assert property (@(posedge clk) disable iff (rst)
        (sync && (per_act >= cnt_t'(2))) |=> !sync);

    // R1: the counter moves by exactly one each clock
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        (per_act != '0) |=> ((cnt == cnt_t'($past(cnt) + cnt_t'(1))) ||
                             (cnt == cnt_t'($past(cnt) - cnt_t'(1)))));

endmodule

bind pwm3_gen pwm3_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pol_high (pol_high),
    .trip_in  (trip_in),
    .pins     (pin_vec),
    .sync     (sync),
    .cnt      (cnt_now),
    .per_act  (per_now),
    .en       (en_q)
);

// File: tb/pwm3_gen_test.sv
module pwm3_gen_test;
    import pwm3_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [2:0]     wr_addr = '0;
    logic [15:0]    wr_data = '0;
    logic           pol_high = 1'b1;
    logic           trip_in = 1'b0;
    logic [NSH-1:0] ext_shut = '0;
    logic           ah, al, bh, bl, ch, cl, sync;
    logic [5:0]     pv;

    int   checks = 0;
    int   fails  = 0;
    logic done   = 1'b0;
    int   ctrl_img = 0;

    typedef struct {
        int    per;
        int    exp[6];
        int    exp_sync;
        logic  pol;
        string tag;
    } item_t;
    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm3_gen #(.NSHUT(NSH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pol_high(pol_high), .trip_in(trip_in), .ext_shut(ext_shut),
        .ah(ah), .al(al), .bh(bh), .bl(bl), .ch(ch), .cl(cl), .sync(sync)
    );

    assign pv = {cl, ch, bl, bh, al, ah};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!sync);
    endtask

    function automatic int exp_hi(int d, int dt, int p, int mw);
        int th;
        th = (d > dt) ? d - dt : 0;
        if (th == 0) return 0;
        if (th > p) return 2 * p;
        if (2 * th - 1 < mw) return 0;
        return 2 * th - 1;
    endfunction

    function automatic int exp_lo(int d, int dt, int p, int mw);
        int th;
        th = d + dt;
        if (th == 0) return 2 * p;
        if (th > p) return 0;
        if (2 * (p - th) + 1 < mw) return 0;
        return 2 * (p - th) + 1;
    endfunction

    // R13: addresses 0 period, 1..3 duty, 4 dead, 5 minw, 6 ctrl, 7 chop divisor
    task automatic cfg(input int p, input int da, input int db, input int dc,
                       input int dt, input int mw, input int ctl, input int cdiv);
        wr(0, p); wr(1, da); wr(2, db); wr(3, dc); wr(4, dt); wr(5, mw);
        wr(7, cdiv); wr(6, ctl);
        ctrl_img = ctl;
        repeat (3) wait_sync();
    endtask

    task automatic expect_win(input string tag, input int p, input int da, input int db,
                              input int dc, input int dt, input int mw, input logic [5:0] en,
                              input logic chh, input logic chl, input logic pol, input int ns);
        item_t it;
        int d[3];
        d = '{da, db, dc};
        it.per = p;
        for (int k = 0; k < 3; k++) begin
            int h, l;
            h = exp_hi(d[k], dt, p, mw);
            l = exp_lo(d[k], dt, p, mw);
            it.exp[2*k]   = en[2*k]   ? (chh ? h / 2 : h) : 0;
            it.exp[2*k+1] = en[2*k+1] ? (chl ? l / 2 : l) : 0;
        end
        it.exp_sync = ns;
        it.pol = pol;
        it.tag = tag;
        @(negedge clk);
        sbq.push_back(it);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // monitor: measures one full period starting at a sync pulse
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() != 0 && sync) begin
                item_t it;
                int c[6];
                int ns;
                it = sbq[0];
                ns = 0;
                for (int j = 0; j < 6; j++) c[j] = 0;
                for (int k = 0; k < 2 * it.per; k++) begin
                    if (k > 0) @(negedge clk);
                    for (int j = 0; j < 6; j++) if (pv[j] == it.pol) c[j]++;
                    if (sync) ns++;
                end
                void'(sbq.pop_front());
                for (int j = 0; j < 6; j++)
                    check(c[j] == it.exp[j], $sformatf("%s out%0d", it.tag, j), c[j], it.exp[j]);
                check(ns == it.exp_sync, $sformatf("%s sync count", it.tag), ns, it.exp_sync);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog R1 run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R7: enables clear after reset, so every pin is inactive
        check(pv == 6'b000000, "R7 reset outputs inactive", pv, 0);

        // R1: reset period 100 gives 200 clocks between sync pulses
        wait_sync();
        n = 0;
        do begin @(negedge clk); n++; end while (!sync);
        check(n == 200, "R1 reset period length", n, 200);

        // R2 R3 R1: base pattern, phase C in overmodulation, single update
        cfg(20, 10, 5, 25, 2, 0, 32'h7E, 0);
        expect_win("R2 R3 R1 base", 20, 10, 5, 25, 2, 0, 6'h3F, 0, 0, 1'b1, 1);
        drain();

        // R5: double update doubles the sync pulses, widths unchanged
        cfg(20, 10, 5, 25, 2, 0, 32'h7F, 0);
        expect_win("R5 double update", 20, 10, 5, 25, 2, 0, 6'h3F, 0, 0, 1'b1, 2);
        drain();

        // R6: write right after sync; running period keeps old duty
        cfg(20, 10, 5, 25, 2, 0, 32'h7E, 0);
        expect_win("R6 old period", 20, 10, 5, 25, 2, 0, 6'h3F, 0, 0, 1'b1, 1);
        expect_win("R6 new period", 20, 14, 5, 25, 2, 0, 6'h3F, 0, 0, 1'b1, 1);
        wait_sync();
        wr(1, 14);
        drain();

        // R4: minimum width 6 removes short pulses (B high 5, C high 1)
        cfg(20, 10, 5, 3, 2, 6, 32'h7E, 0);
        expect_win("R4 min width", 20, 10, 5, 3, 2, 6, 6'h3F, 0, 0, 1'b1, 1);
        drain();

        // R7 R8: AH and CL disabled, active-low polarity
        pol_high = 1'b0;
        cfg(20, 10, 5, 25, 2, 0, 6'b011110 << 1, 0);
        expect_win("R7 R8 enables low polarity", 20, 10, 5, 25, 2, 0, 6'b011110, 0, 0, 1'b0, 1);
        drain();
        pol_high = 1'b1;

        // R9: chop both sides, divisor 0, only A and B enabled
        cfg(20, 25, 0, 10, 0, 0, (6'b001111 << 1) | (1 << 7) | (1 << 8), 0);
        expect_win("R9 chop div0", 20, 25, 0, 10, 0, 0, 6'b001111, 1, 1, 1'b1, 1);
        drain();
        cfg(20, 25, 0, 10, 0, 0, (6'b001111 << 1) | (1 << 7) | (1 << 8), 1);
        expect_win("R9 chop div1", 20, 25, 0, 10, 0, 0, 6'b001111, 1, 1, 1'b1, 1);
        drain();

        // R10 R11 R12: shutdown path, CH held fully on
        cfg(20, 10, 5, 25, 2, 0, 32'h7E, 0);
        @(negedge clk);
        #1 trip_in = 1'b1;
        #1 check(pv == 6'b000000, "R10 async trip", pv, 0);
        check(ch == 1'b0, "R10 async trip CH", ch, 0);
        repeat (3) @(negedge clk);
        trip_in = 1'b0;
        repeat (3) @(negedge clk);
        check(pv == 6'b000000, "R10 latched after release", pv, 0);

        trip_in = 1'b1;
        wr(6, ctrl_img | 32'h8000);
        repeat (3) @(negedge clk);
        trip_in = 1'b0;
        repeat (3) @(negedge clk);
        check(pv == 6'b000000, "R12 clear ignored while trip high", pv, 0);

        wr(6, ctrl_img | 32'h8000);
        repeat (3) @(negedge clk);
        check(ch == 1'b1, "R12 clear releases", ch, 1);

        @(negedge clk);
        ext_shut = 2'b10;
        @(negedge clk);
        ext_shut = 2'b00;
        repeat (2) @(negedge clk);
        check(ch == 1'b0, "R11 ext shutdown", ch, 0);
        wr(6, ctrl_img | 32'h8000);
        repeat (3) @(negedge clk);
        check(ch == 1'b1, "R11 R12 clear after ext shutdown", ch, 1);

        expect_win("R10 resume after clear", 20, 10, 5, 25, 2, 0, 6'h3F, 0, 0, 1'b1, 1);
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule